// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block decides, once per system clock, whether a 16-bit timer/counter advances. A 3-bit select code picks one of five sources: nothing (counter held), a prescaled system-clock tick, a slow-clock tick, edge events on an external input pin, or prescaled ticks gated by the level of that same pin (pulse accumulation). The result is a single-cycle count-enable strobe that the counter consumes directly. The prescaler, the slow-clock generator and the counter itself sit outside.

The external pin is asynchronous. It passes through a synchroniser chain of `SYNC_STAGES` flops. A priming counter blocks all pin-derived events until the chain and the edge-history flop hold real samples. One polarity bit chooses the active edge in event mode and the active level in accumulate mode. The two pin-based sources are legal only in the two timer modes that have no capture inputs. In the other two modes they are inert, and so are the three unassigned select codes.

Top module: `timer_clk_sel`

## Requirements
- R1: Select code 000 produces no count-enable strobes, whatever the other inputs do.
- R2: Select code 001 makes `cnt_en` follow `presc_tick`, one clock later.
- R3: Select code 010 in modes 00 or 10 gives a one-cycle strobe for each active pin edge. `edge_pol`=1 selects rising edges and 0 selects falling edges. With the default depth, the strobe appears on the third clock edge after the pin changes.
- R4: Select code 011 in modes 00 or 10 makes `cnt_en` follow `presc_tick` while the synchronised pin is at the active level: high when `edge_pol`=1, low when 0. Otherwise `cnt_en` is 0. A pin change reaches the gate after `SYNC_STAGES` edges.
- R5: Select code 100 makes `cnt_en` follow `slow_tick`, one clock later.
- R6: Select codes 101, 110 and 111 produce no strobes.
- R7: Select codes 010 and 011 produce no strobes in modes 01 and 11.
- R8: After reset, `cnt_en` is 0. No pin-derived strobe is produced during the first `SYNC_STAGES`+1 clock edges after reset is released, even if the pin already sits at an active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_code | input | 3 | Count source select code |
| timer_mode | input | 2 | Timer operating mode (00, 01, 10, 11) |
| edge_pol | input | 1 | Active edge/level for the external pin (1 = rising/high) |
| presc_tick | input | 1 | Prescaled system-clock tick |
| slow_tick | input | 1 | Slow-clock tick |
| ext_pin | input | 1 | Asynchronous external event pin |
| cnt_en | output | 1 | Single-cycle count-enable strobe |

## Verification
The bound checker covers the source relationships that hold on every cycle: the stopped, undefined and mode-blocked codes never strobe; the prescaled and slow codes track their tick one clock later; accumulation never strobes without a prescaled tick; and an event strobe never lasts two cycles. The bench scenarios are needed for what depends on pin history. These are the exact synchroniser latency, the choice of edge or level by polarity, the priming window after reset, and the absence of strobes across long pin-toggle sequences in blocked modes.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

   typedef enum logic [2:0] {
      SEL_STOP  = 3'b000,
      SEL_PRESC = 3'b001,
      SEL_EXT   = 3'b010,
      SEL_ACCUM = 3'b011,
      SEL_SLOW  = 3'b100
   } sel_code_e;

   typedef enum logic [1:0] {
      MODE_PWM_SYS  = 2'b00,
      MODE_DUAL_CAP = 2'b01,
      MODE_DUAL_TMR = 2'b10,
      MODE_CAP_TMR  = 2'b11
   } timer_mode_e;

   typedef enum logic [2:0] {
      SRC_NONE,
      SRC_PRESC,
      SRC_EDGE,
      SRC_LEVEL,
      SRC_SLOW
   } src_e;

   // Pin-based sources exist only in modes without capture inputs.
   function automatic logic pin_src_legal(input logic [1:0] mode);
      return (mode == MODE_PWM_SYS) || (mode == MODE_DUAL_TMR);
   endfunction

endpackage

// File: rtl/tcs_pin_sync.sv
module tcs_pin_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   input  logic pol,
   output logic edge_evt,
   output logic level_ok
);
   localparam int FILL   = SYNC_STAGES + 1;
   localparam int FILL_W = $clog2(FILL + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("tcs_pin_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   hist_q;
   logic [FILL_W-1:0]      fill_q;
   logic                   primed;
   logic                   cur;

   // Synchroniser chain plus one history flop for edge detection.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         hist_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], pin_async};
         hist_q  <= chain_q[SYNC_STAGES-1];
      end
   end

   // Priming counter: blocks events until every flop holds a real sample.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= '0;
      end else if (fill_q != FILL_W'(FILL)) begin
         fill_q <= fill_q + 1'b1;
      end
   end

   assign primed = (fill_q == FILL_W'(FILL));
   assign cur    = chain_q[SYNC_STAGES-1];

   always_comb begin
      if (pol) edge_evt = primed & cur & ~hist_q;
      else     edge_evt = primed & ~cur & hist_q;
      level_ok = primed & (cur == pol);
   end

endmodule

// File: rtl/tcs_src_qual.sv
module tcs_src_qual
   import tcs_pkg::*;
(
   input  logic [2:0] sel_code,
   input  logic [1:0] timer_mode,
   output src_e       src
);
   logic pin_ok;

   assign pin_ok = pin_src_legal(timer_mode);

   always_comb begin
      case (sel_code)
         SEL_PRESC: src = SRC_PRESC;
         SEL_EXT:   src = pin_ok ? SRC_EDGE  : SRC_NONE;
         SEL_ACCUM: src = pin_ok ? SRC_LEVEL : SRC_NONE;
         SEL_SLOW:  src = SRC_SLOW;
         default:   src = SRC_NONE;
      endcase
   end

endmodule

// File: rtl/tcs_strobe_mux.sv
module tcs_strobe_mux
   import tcs_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  src_e src,
   input  logic presc_tick,
   input  logic slow_tick,
   input  logic edge_evt,
   input  logic level_ok,
   output logic strobe
);
   logic strobe_d;

   always_comb begin
      unique case (src)
         SRC_PRESC: strobe_d = presc_tick;
         SRC_EDGE:  strobe_d = edge_evt;
         SRC_LEVEL: strobe_d = presc_tick & level_ok;
         SRC_SLOW:  strobe_d = slow_tick;
         default:   strobe_d = 1'b0;
      endcase
   end

   generate
      if (OUT_REG) begin : g_reg
         logic strobe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) strobe_q <= 1'b0;
            else        strobe_q <= strobe_d;
         end
         assign strobe = strobe_q;
      end else begin : g_comb
         assign strobe = strobe_d;
      end
   endgenerate

endmodule

// File: rtl/timer_clk_sel.sv
module timer_clk_sel
   import tcs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel_code,
   input  logic [1:0] timer_mode,
   input  logic       edge_pol,
   input  logic       presc_tick,
   input  logic       slow_tick,
   input  logic       ext_pin,
   output logic       cnt_en
);
   src_e src;
   logic edge_evt;
   logic level_ok;

   tcs_pin_sync #(
      .SYNC_STAGES(SYNC_STAGES)
   ) pin_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (ext_pin),
      .pol       (edge_pol),
      .edge_evt  (edge_evt),
      .level_ok  (level_ok)
   );

   tcs_src_qual qual_i (
      .sel_code   (sel_code),
      .timer_mode (timer_mode),
      .src        (src)
   );

   tcs_strobe_mux #(
      .OUT_REG(OUT_REG)
   ) mux_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .src        (src),
      .presc_tick (presc_tick),
      .slow_tick  (slow_tick),
      .edge_evt   (edge_evt),
      .level_ok   (level_ok),
      .strobe     (cnt_en)
   );

endmodule

// File: rtl/timer_clk_sel_checker.sv
module timer_clk_sel_checker #(
   parameter bit OUT_REG = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] sel_code,
   input logic [1:0] timer_mode,
   input logic       presc_tick,
   input logic       slow_tick,
   input logic       cnt_en
);
   generate
      if (OUT_REG) begin : g_chk
         assert_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_code == 3'b000) |=> !cnt_en);

         assert_presc_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_code == 3'b001) |=> (cnt_en == $past(presc_tick)));

         assert_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_code == 3'b010 && $past(sel_code) == 3'b010 && cnt_en) |=> !cnt_en);

         assert_accum_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_code == 3'b011 && !presc_tick) |=> !cnt_en);

         assert_slow_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_code == 3'b100) |=> (cnt_en == $past(slow_tick)));

         assert_undef_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_code >= 3'b101) |=> !cnt_en);

         assert_mode_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((sel_code == 3'b010 || sel_code == 3'b011) && timer_mode[0]) |=> !cnt_en);
      end
   endgenerate

endmodule

bind timer_clk_sel timer_clk_sel_checker #(
   .OUT_REG(OUT_REG)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel_code   (sel_code),
   .timer_mode (timer_mode),
   .presc_tick (presc_tick),
   .slow_tick  (slow_tick),
   .cnt_en     (cnt_en)
);

// File: tb/timer_clk_sel_tb.sv
`timescale 1ns/1ps
module timer_clk_sel_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] sel_code = 3'b000;
   logic [1:0] timer_mode = 2'b00;
   logic       edge_pol = 1'b0;
   logic       presc_tick = 1'b0;
   logic       slow_tick = 1'b0;
   logic       ext_pin = 1'b0;
   logic       cnt_en;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   timer_clk_sel dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_code   (sel_code),
      .timer_mode (timer_mode),
      .edge_pol   (edge_pol),
      .presc_tick (presc_tick),
      .slow_tick  (slow_tick),
      .ext_pin    (ext_pin),
      .cnt_en     (cnt_en)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic exp);
      checks++;
      if (cnt_en !== exp) begin
         errors++;
         $display("FAIL %s: cnt_en=%b expected=%b at %0t", req, cnt_en, exp, $time);
      end
   endtask

   task automatic settle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic t_reset_and_fill();
      rst_n = 1'b0;
      sel_code = 3'b011; timer_mode = 2'b00; edge_pol = 1'b1;
      ext_pin = 1'b1; presc_tick = 1'b1;
      settle(2);
      check("R8 reset", 1'b0);
      rst_n = 1'b1;
      // priming takes 3 edges; first strobe registered on the 4th
      tick(); check("R8 fill1", 1'b0);
      tick(); check("R8 fill2", 1'b0);
      tick(); check("R8 fill3", 1'b0);
      tick(); check("R8 primed", 1'b1);
      presc_tick = 1'b0;
      tick(); check("R4 tick gone", 1'b0);
   endtask

   task automatic t_stop();
      sel_code = 3'b000; presc_tick = 1'b1; slow_tick = 1'b1;
      for (int i = 0; i < 6; i++) begin
         ext_pin = ~ext_pin;
         tick(); check("R1 stop", 1'b0);
      end
      presc_tick = 1'b0; slow_tick = 1'b0;
   endtask

   task automatic t_presc();
      sel_code = 3'b001; slow_tick = 1'b1;
      presc_tick = 1'b1; tick(); check("R2 tick hi", 1'b1);
      presc_tick = 1'b0; tick(); check("R2 tick lo", 1'b0);
      presc_tick = 1'b1; tick(); check("R2 tick hi again", 1'b1);
      presc_tick = 1'b0; slow_tick = 1'b0; tick(); check("R2 tick lo again", 1'b0);
   endtask

   task automatic t_slow();
      sel_code = 3'b100; presc_tick = 1'b1;
      slow_tick = 1'b0; tick(); check("R5 slow lo", 1'b0);
      slow_tick = 1'b1; tick(); check("R5 slow hi", 1'b1);
      slow_tick = 1'b0; presc_tick = 1'b0; tick(); check("R5 slow lo after", 1'b0);
   endtask

   task automatic edge_run(input logic pol, input logic [1:0] mode, input string req);
      sel_code = 3'b010; timer_mode = mode; edge_pol = pol;
      ext_pin = ~pol; settle(4);
      check({req, " idle"}, 1'b0);
      ext_pin = pol;   // active edge
      tick(); check({req, " e1"}, 1'b0);
      tick(); check({req, " e2"}, 1'b0);
      tick(); check({req, " e3 strobe"}, 1'b1);
      tick(); check({req, " e4 single"}, 1'b0);
      ext_pin = ~pol;  // inactive edge
      for (int i = 0; i < 5; i++) begin
         tick(); check({req, " inactive edge"}, 1'b0);
      end
   endtask

   task automatic t_ext();
      edge_run(1'b1, 2'b00, "R3 rising mode00");
      edge_run(1'b0, 2'b10, "R3 falling mode10");
   endtask

   task automatic t_accum();
      sel_code = 3'b011; timer_mode = 2'b10; edge_pol = 1'b1;
      presc_tick = 1'b1; ext_pin = 1'b0; settle(4);
      check("R4 pin low pol1", 1'b0);
      ext_pin = 1'b1;
      tick(); check("R4 lat1", 1'b0);
      tick(); check("R4 lat2", 1'b0);
      tick(); check("R4 active high", 1'b1);
      tick(); check("R4 stays", 1'b1);
      presc_tick = 1'b0; tick(); check("R4 no tick", 1'b0);
      presc_tick = 1'b1; edge_pol = 1'b0;
      tick(); check("R4 pol0 pin high", 1'b0);
      ext_pin = 1'b0;
      tick(); check("R4 pol0 lat1", 1'b0);
      tick(); check("R4 pol0 lat2", 1'b0);
      tick(); check("R4 active low", 1'b1);
      presc_tick = 1'b0; tick(); check("R4 pol0 no tick", 1'b0);
   endtask

   task automatic t_undef();
      presc_tick = 1'b1; slow_tick = 1'b1; timer_mode = 2'b00; edge_pol = 1'b1;
      for (int c = 5; c < 8; c++) begin
         sel_code = 3'(c);
         for (int i = 0; i < 6; i++) begin
            ext_pin = ~ext_pin;
            tick(); check($sformatf("R6 code %0d", c), 1'b0);
         end
      end
      presc_tick = 1'b0; slow_tick = 1'b0;
   endtask

   task automatic t_mode_block();
      presc_tick = 1'b1;
      for (int m = 1; m < 4; m += 2) begin
         timer_mode = 2'(m);
         for (int c = 2; c < 4; c++) begin
            sel_code = 3'(c);
            for (int p = 0; p < 2; p++) begin
               edge_pol = p[0];
               for (int i = 0; i < 8; i++) begin
                  if (i % 3 == 0) ext_pin = ~ext_pin;
                  tick();
                  check($sformatf("R7 mode %0d code %0d", m, c), 1'b0);
               end
            end
         end
      end
      presc_tick = 1'b0;
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2;
      t_reset_and_fill();
      t_stop();
      t_presc();
      t_slow();
      t_ext();
      t_accum();
      t_undef();
      t_mode_block();
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule